// File: doc/BRIEF.md
# Frame-Aligned Receive Gate with Control Register

This block sits between the receive side of an Ethernet PHY and the MAC. It holds a four-bit control register that a host reaches through a simple synchronous port: one address compare, a write strobe and a combinational read-back. The block acts on three things the register selects:

- A receive-disable bit closes a gate on the received stream (valid, data, error) toward the MAC. The gate only opens or closes between frames, so the MAC never sees a fragment. A frame starts at the rising edge of the receive-valid input and ends at its falling edge.
- Two LED-mode bits choose which status input drives each of the two LED outputs.
- A self-clearing soft-reset bit returns the register and the gate to their initial state.

A compatibility-mode input locks the receive-disable and soft-reset bits. While it is high, writes to those two bits are ignored and both bits act as cleared. The link-status input passes straight through and never depends on the gate.

Top module: `rxg_top`

## Requirements
- R1: After reset the register at address `REG_ADDR` reads 0. Its bits are: bit 3 receive-disable, bit 2 LED1 mode, bit 1 LED4 mode, bit 0 soft reset. Bits 3..1 read back what was last written. Any other address reads 0.
- R2: If receive-disable goes to 1 while a frame is in progress, that frame is forwarded to its end. No later frame is forwarded while the bit stays 1.
- R3: If receive-disable goes to 0 while a frame is in progress, that frame stays blocked to its end. The next frame is forwarded.
- R4: While the gate is closed, `rx_valid_o` and `rx_err_o` are 0 and `rx_data_o` is all zeros. While it is open, the three outputs equal their inputs.
- R5: `link_up_o` always equals `link_up_i`, whatever the register holds.
- R6: While `compat_i` is 1:
  - writes to bits 3 and 0 are ignored;
  - bits 3 and 0 read as 0;
  - the gate behaves as if receive-disable were 0.
- R7: `led1_o` follows `cim_ok_i` when LED1 mode is 1, and `tx_act_i` when it is 0.
- R8: `led4_o` follows `full_dup_i` when LED4 mode is 1. When LED4 mode is 0, it follows `full_dup_i` if `speed100_i` is 1 and `polarity_i` if `speed100_i` is 0.
- R9: Writing 1 to bit 0 (with `compat_i` low) clears bits 3..1 and the gate state. Bit 0 then reads 1 for `RST_CYC` cycles and 0 after that. The gate stays closed through the pulse and until receive-valid has been seen low.
- R10: After `rst_ni` is released during a frame, the gate stays closed until receive-valid has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data (combinational) |
| compat_i | input | 1 | Compatibility mode; locks bits 3 and 0 |
| rx_valid_i | input | 1 | Receive valid from PHY |
| rx_data_i | input | DATA_W | Receive data from PHY |
| rx_err_i | input | 1 | Receive error from PHY |
| rx_valid_o | output | 1 | Gated receive valid to MAC |
| rx_data_o | output | DATA_W | Gated receive data to MAC |
| rx_err_o | output | 1 | Gated receive error to MAC |
| link_up_i | input | 1 | Link status in |
| link_up_o | output | 1 | Link status out |
| tx_act_i | input | 1 | Transmit activity |
| cim_ok_i | input | 1 | Carrier-integrity status |
| full_dup_i | input | 1 | Full-duplex status |
| polarity_i | input | 1 | Polarity status (10 Mb/s) |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| led1_o | output | 1 | LED1 drive |
| led4_o | output | 1 | LED4 drive |

## Verification
The bench builds the block with an 8-bit data path, a 5-bit address with the register at 0x17, and a soft-reset pulse of `RST_CYC` = 3. The short pulse lets the bench see bit 0 fall back to 0 within a few cycles. It also leaves room, inside one random frame, for the case where a soft reset lands mid-frame and the gate must wait for the next idle cycle. The 8-bit data width makes a wrongly zeroed or leaked data byte show up in almost every cycle.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int CTRL_W    = 4;
  localparam int BIT_RXDIS = 3;
  localparam int BIT_LED1  = 2;
  localparam int BIT_LED4  = 1;
  localparam int BIT_SRST  = 0;

  typedef struct packed {
    logic rx_dis;
    logic led1_mode;
    logic led4_mode;
  } ctrl_t;
endpackage

// File: rtl/rxg_ctrl_reg.sv
module rxg_ctrl_reg
  import rxg_pkg::*;
#(
  parameter int          ADDR_W   = 5,
  parameter logic [4:0]  REG_ADDR = 5'h17,
  parameter int          RST_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              compat_i,
  output logic [CTRL_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              rx_dis_o,
  output logic              srst_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYC);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             sel;
  logic             wr_hit;

  assign sel    = (addr_i == REG_ADDR[ADDR_W-1:0]);
  assign wr_hit = wr_i & sel;
  assign srst_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
    end else if (srst_o) begin
      ctrl_q <= '0;
      cnt_q  <= cnt_q - 1'b1;
    end else if (wr_hit) begin
      if (!compat_i && wdata_i[BIT_SRST]) begin
        ctrl_q <= '0;
        cnt_q  <= CNT_LOAD;
      end else begin
        if (!compat_i) ctrl_q.rx_dis <= wdata_i[BIT_RXDIS];
        ctrl_q.led1_mode <= wdata_i[BIT_LED1];
        ctrl_q.led4_mode <= wdata_i[BIT_LED4];
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign rx_dis_o = ctrl_q.rx_dis & ~compat_i;

  always_comb begin
    rdata_o = '0;
    if (sel) begin
      rdata_o[BIT_RXDIS] = rx_dis_o;
      rdata_o[BIT_LED1]  = ctrl_q.led1_mode;
      rdata_o[BIT_LED4]  = ctrl_q.led4_mode;
      rdata_o[BIT_SRST]  = srst_o & ~compat_i;
    end
  end
endmodule

// File: rtl/rxg_frame_gate.sv
module rxg_frame_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              rx_dis_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_err_o
);
  // prev_q resets high so a frame in flight at reset is not taken as a start
  logic prev_q;
  logic pass_q;
  logic pass_now;
  logic fwd;

  assign pass_now = ~srst_i & (prev_q ? pass_q : ~rx_dis_i);
  assign fwd      = pass_now & rx_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pass_q <= 1'b0;
    end else if (srst_i) begin
      prev_q <= 1'b1;
      pass_q <= 1'b0;
    end else begin
      prev_q <= rx_valid_i;
      pass_q <= pass_now;
    end
  end

  assign rx_valid_o = fwd;
  assign rx_err_o   = fwd & rx_err_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dmask
    assign rx_data_o[i] = rx_data_i[i] & fwd;
  end
endmodule

// File: rtl/rxg_led_mux.sv
module rxg_led_mux (
  input  logic led1_mode_i,
  input  logic led4_mode_i,
  input  logic tx_act_i,
  input  logic cim_ok_i,
  input  logic full_dup_i,
  input  logic polarity_i,
  input  logic speed100_i,
  output logic led1_o,
  output logic led4_o
);
  assign led1_o = led1_mode_i ? cim_ok_i : tx_act_i;
  assign led4_o = (led4_mode_i || speed100_i) ? full_dup_i : polarity_i;
endmodule

// File: rtl/rxg_top.sv
module rxg_top
  import rxg_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 5,
  parameter logic [4:0]  REG_ADDR = 5'h17,
  parameter int          RST_CYC  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_wdata_i,
  output logic [3:0]        reg_rdata_o,
  input  logic              compat_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_err_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_err_o,
  input  logic              link_up_i,
  output logic              link_up_o,
  input  logic              tx_act_i,
  input  logic              cim_ok_i,
  input  logic              full_dup_i,
  input  logic              polarity_i,
  input  logic              speed100_i,
  output logic              led1_o,
  output logic              led4_o
);
  ctrl_t ctrl;
  logic  rx_dis;
  logic  srst;

  rxg_ctrl_reg #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_CYC(RST_CYC)
  ) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .compat_i(compat_i), .rdata_o(reg_rdata_o),
    .ctrl_o(ctrl), .rx_dis_o(rx_dis), .srst_o(srst)
  );

  rxg_frame_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst), .rx_dis_i(rx_dis),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_err_i(rx_err_i),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_err_o(rx_err_o)
  );

  rxg_led_mux u_led (
    .led1_mode_i(ctrl.led1_mode), .led4_mode_i(ctrl.led4_mode),
    .tx_act_i(tx_act_i), .cim_ok_i(cim_ok_i), .full_dup_i(full_dup_i),
    .polarity_i(polarity_i), .speed100_i(speed100_i),
    .led1_o(led1_o), .led4_o(led4_o)
  );

  assign link_up_o = link_up_i;
endmodule

// File: rtl/rxg_chk.sv
module rxg_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              compat_i,
  input logic              link_up_i,
  input logic              link_up_o,
  input logic              rx_valid_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_err_o,
  input logic [3:0]        reg_rdata_o,
  input logic              soft_rst,
  input logic              led1_mode,
  input logic              led4_mode
);
  // R4
  closed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> (rx_data_o == '0) && !rx_err_o);

  // R3
  no_mid_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && $past(rx_valid_i) && !$past(rx_valid_o) |-> !rx_valid_o);

  // R2
  no_mid_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i && $past(rx_valid_i) && $past(rx_valid_o) && !soft_rst |-> rx_valid_o);

  // R5
  link_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o == link_up_i);

  // R6
  compat_hide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compat_i |-> !reg_rdata_o[3] && !reg_rdata_o[0]);

  // R9
  srst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> !led1_mode && !led4_mode);
endmodule

bind rxg_top rxg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .compat_i(compat_i),
  .link_up_i(link_up_i), .link_up_o(link_up_o),
  .rx_valid_i(rx_valid_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
  .rx_err_o(rx_err_o), .reg_rdata_o(reg_rdata_o), .soft_rst(srst),
  .led1_mode(ctrl.led1_mode), .led4_mode(ctrl.led4_mode)
);

// File: tb/tb_rxg_top.sv
module tb_rxg_top;
  localparam int         DATA_W   = 8;
  localparam int         ADDR_W   = 5;
  localparam logic [4:0] REG_ADDR = 5'h17;
  localparam int         RST_CYC  = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = REG_ADDR;
  logic reg_wr_i = 0;
  logic [3:0] reg_wdata_i = 0, reg_rdata_o;
  logic compat_i = 0, rx_valid_i = 0, rx_err_i = 0;
  logic [DATA_W-1:0] rx_data_i = 0, rx_data_o;
  logic rx_valid_o, rx_err_o, link_up_i = 0, link_up_o;
  logic tx_act_i = 0, cim_ok_i = 0, full_dup_i = 0, polarity_i = 0, speed100_i = 0;
  logic led1_o, led4_o;

  always #2 clk_i = ~clk_i;

  rxg_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_CYC(RST_CYC)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_dis, m_l1, m_l4, m_prev = 1, m_pass = 0;
  int m_cnt = 0;

  function automatic bit pass_now();
    bit dis_eff = m_dis & ~compat_i;
    if (m_cnt != 0) return 0;
    return m_prev ? m_pass : ~dis_eff;
  endfunction

  function automatic logic [3:0] exp_rdata();
    if (reg_addr_i != REG_ADDR) return 4'h0;
    return {m_dis & ~compat_i, m_l1, m_l4, (m_cnt != 0) & ~compat_i};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: inputs already driven after negedge
  task automatic cyc(string tag);
    bit pn, fwd;
    #1;
    pn  = pass_now();
    fwd = pn & rx_valid_i;
    chk(tag, {rx_valid_o, rx_err_o, rx_data_o},
        {fwd, fwd & rx_err_i, fwd ? rx_data_i : {DATA_W{1'b0}}});
    chk("R5", link_up_o, link_up_i);
    chk("R7", led1_o, m_l1 ? cim_ok_i : tx_act_i);
    chk("R8", led4_o, m_l4 ? full_dup_i : (speed100_i ? full_dup_i : polarity_i));
    chk(tag, reg_rdata_o, exp_rdata());
    @(posedge clk_i);
    if (m_cnt != 0) begin
      m_cnt--; m_dis = 0; m_l1 = 0; m_l4 = 0; m_prev = 1; m_pass = 0;
    end else begin
      m_prev = rx_valid_i; m_pass = pn;
      if (reg_wr_i && reg_addr_i == REG_ADDR) begin
        if (!compat_i && reg_wdata_i[0]) begin
          m_dis = 0; m_l1 = 0; m_l4 = 0; m_cnt = RST_CYC;
        end else begin
          if (!compat_i) m_dis = reg_wdata_i[3];
          m_l1 = reg_wdata_i[2]; m_l4 = reg_wdata_i[1];
        end
      end
    end
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic wr(logic [3:0] d, string tag);
    reg_addr_i = REG_ADDR; reg_wr_i = 1; reg_wdata_i = d;
    cyc(tag);
  endtask

  task automatic frame(int len, string tag);
    for (int i = 0; i < len; i++) begin
      rx_valid_i = 1; rx_data_i = DATA_W'($urandom); cyc(tag);
    end
    rx_valid_i = 0; cyc(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit in_frm = 0;
    void'($urandom(32'd5150));
    // R10: reset released mid-frame
    rx_valid_i = 1; rx_data_i = 8'hA5;
    #7;
    chk("R1", reg_rdata_o, 4'h0);
    chk("R4", rx_valid_o, 1'b0);
    @(negedge clk_i); rst_ni = 1;
    for (int i = 0; i < 3; i++) cyc("R10");
    rx_valid_i = 0; cyc("R10");
    frame(4, "R10");

    // R1: register map
    wr(4'b1110, "R1"); cyc("R1");
    chk("R1", reg_rdata_o, 4'b1110);
    wr(4'b0100, "R1");
    reg_addr_i = 5'h03; cyc("R1");
    chk("R1", reg_rdata_o, 4'h0);
    reg_addr_i = REG_ADDR;
    wr(4'b0000, "R1");

    // R2: disable mid-frame
    rx_valid_i = 1; rx_data_i = 8'h11; cyc("R2");
    rx_data_i = 8'h22; cyc("R2");
    wr(4'b1000, "R2");
    rx_data_i = 8'h33; #1;
    chk("R2", {rx_valid_o, rx_data_o}, {1'b1, 8'h33});
    cyc("R2");
    rx_valid_i = 0; cyc("R2");
    rx_valid_i = 1; rx_data_i = 8'h44; #1;
    chk("R2", {rx_valid_o, rx_data_o}, 9'h0);
    cyc("R2");
    // R3: enable mid-frame
    wr(4'b0000, "R3");
    rx_data_i = 8'h55; #1;
    chk("R3", rx_valid_o, 1'b0);
    cyc("R3");
    rx_valid_i = 0; cyc("R3");
    rx_valid_i = 1; rx_data_i = 8'h66; #1;
    chk("R3", {rx_valid_o, rx_data_o}, {1'b1, 8'h66});
    cyc("R3");
    rx_valid_i = 0; cyc("R3");
    // R4: error while blocked
    wr(4'b1000, "R4");
    rx_valid_i = 1; rx_err_i = 1; cyc("R4"); cyc("R4");
    rx_valid_i = 0; rx_err_i = 0; cyc("R4");

    // R6: compat lock
    compat_i = 1;
    cyc("R6");
    frame(3, "R6");
    wr(4'b0001, "R6");
    chk("R6", reg_rdata_o, 4'b0000);
    wr(4'b1110, "R6");
    chk("R6", reg_rdata_o, 4'b0110);
    compat_i = 0; cyc("R6");
    chk("R6", reg_rdata_o, 4'b1110);

    // R9: soft reset mid-frame
    rx_valid_i = 1; cyc("R9");
    wr(4'b0001, "R9");
    chk("R9", reg_rdata_o, 4'b0001);
    for (int i = 0; i < RST_CYC; i++) cyc("R9");
    chk("R9", reg_rdata_o, 4'b0000);
    cyc("R9");
    rx_valid_i = 0; cyc("R9");
    frame(3, "R9");

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (in_frm) in_frm = ($urandom % 8) != 0;
      else        in_frm = ($urandom % 3) == 0;
      rx_valid_i = in_frm;
      rx_data_i  = DATA_W'($urandom);
      rx_err_i   = ($urandom % 10) == 0;
      {link_up_i, tx_act_i, cim_ok_i, full_dup_i, polarity_i, speed100_i} = 6'($urandom);
      if (($urandom % 200) == 0) compat_i = ~compat_i;
      reg_addr_i = (($urandom % 8) == 0) ? ADDR_W'($urandom) : REG_ADDR;
      reg_wr_i = ($urandom % 9) == 0;
      reg_wdata_i = 4'($urandom);
      if (reg_wdata_i[0] && ($urandom % 4) != 0) reg_wdata_i[0] = 0;
      cyc("R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule